// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block generates the external bus timing for a small 8-bit processor whose low address byte and data byte travel on one shared set of lines. A requester presents a cycle kind, a 16-bit address and a write byte together with a one-cycle start strobe. The sequencer then steps through one clock period per T-state. It first puts the low address byte on the shared lines with the address strobe high, then turns those lines over to data under active-low read or write strobes. The upper address byte sits on its own lines for the whole cycle.

An instruction fetch takes four T-states and every other kind takes three. Each kind drives its own memory/IO select and two status bits. For reads, the byte on the shared lines is captured at the end of the third T-state and returned with a one-cycle completion pulse. Writes also end with a completion pulse. A two-byte instruction is simply a fetch request followed by a memory read request at the next address. An example is opcode 3Eh at 2000h followed by operand FFh at 2001h.

Top module: `busCycleSeq`

## Requirements
- R1: Out of reset and whenever no cycle is running: `busyOut`=0, `aleOut`=0, `rdNOut`=1, `wrNOut`=1, `adOeOut`=0, `ioMOut`=0, `s1Out`=0, `s0Out`=0, `addrHiOut`=0.
- R2: A start is accepted only when idle and only for kind codes 0 (fetch), 1 (memory read), 2 (memory write), 3 (I/O read) and 4 (I/O write). Codes 5 to 7 are ignored. A start, or any change of kind, address or write byte, while busy does not alter the running cycle and does not queue another one.
- R3: An accepted start makes T1 the next clock period. A fetch is busy for exactly 4 periods (T1 to T4) and the other kinds for exactly 3 (T1 to T3).
- R4: `aleOut` is 1 in T1 only. In T1 the shared lines are driven (`adOeOut`=1) with the low address byte.
- R5: `addrHiOut` equals address bits 15..8 for memory kinds. For I/O kinds it equals the port number (address bits 7..0), and the T1 low byte is that same port number. The value holds for the whole cycle.
- R6: `ioMOut` is 0 for fetch and memory kinds and 1 for I/O kinds. {`s1Out`,`s0Out`} is 11 for fetch, 10 for reads and 01 for writes, for the whole cycle.
- R7: `rdNOut` is 0 in T2 and T3 of fetch and read kinds. `wrNOut` is 0 in T2 and T3 of write kinds. Both are 1 in T1 and T4, and they are never 0 together.
- R8: In T2 and T3 of a write, the shared lines are driven with the write byte. In a fetch or read they are released (`adOeOut`=0) from T2 to the end of the cycle.
- R9: For fetch and read kinds, `adIn` is sampled on the clock edge that ends T3 and appears on `rdDataOut` in the next period, with `doneOut`=1 for that one period. Writes also raise `doneOut` for one period there. `rdDataOut` holds its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period per T-state |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Request strobe |
| kindIn | input | 3 | Cycle kind code (0..4 valid) |
| addrIn | input | 16 | Request address (port number in bits 7..0 for I/O) |
| wrDataIn | input | 8 | Byte to write |
| adIn | input | 8 | Shared lines as seen from the bus |
| busyOut | output | 1 | Cycle in progress |
| doneOut | output | 1 | One-period completion pulse |
| rdDataOut | output | 8 | Last captured read byte |
| addrHiOut | output | 8 | Upper address lines |
| adOut | output | 8 | Value driven onto the shared lines |
| adOeOut | output | 1 | Drive enable for the shared lines |
| aleOut | output | 1 | Address latch strobe |
| ioMOut | output | 1 | 1 for I/O space, 0 for memory |
| s1Out | output | 1 | Status bit 1 |
| s0Out | output | 1 | Status bit 0 |
| rdNOut | output | 1 | Active-low read strobe |
| wrNOut | output | 1 | Active-low write strobe |

## Verification
Assertions watch properties on every cycle. Read and write strobes are never active together, and each strobe stays low for exactly two periods. The address strobe lasts one period and opens every cycle. Completion is a single-period pulse that follows the capture. The shared lines are driven after T1 only by writes, and status is quiet when idle. Other behaviours only the bench scenarios can show, because they need a model of what the block was asked to do. These are the exact bus values per T-state for every kind across an address sweep, and the correct byte returned through a bus-side memory model that decodes the address from the strobed low byte. The bench also shows that illegal kind codes and mid-cycle requests are ignored, and that read data holds across writes.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    KIND_FETCH  = 3'd0,
    KIND_MEM_RD = 3'd1,
    KIND_MEM_WR = 3'd2,
    KIND_IO_RD  = 3'd3,
    KIND_IO_WR  = 3'd4
  } cycKind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } tState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // latch the request this edge
    logic active;     // a cycle is running
    logic driveAddr;  // low address byte on shared lines
    logic driveData;  // write byte on shared lines
    logic capture;    // sample shared lines this edge
    logic finish;     // last data T-state
  } seqStrobe_t;

  function automatic logic kindValid(input logic [2:0] k);
    return (k <= 3'd4);
  endfunction

  function automatic logic kindFetch(input logic [2:0] k);
    return (k == KIND_FETCH);
  endfunction

  function automatic logic kindReads(input logic [2:0] k);
    return (k == KIND_FETCH) || (k == KIND_MEM_RD) || (k == KIND_IO_RD);
  endfunction

  function automatic logic kindWrites(input logic [2:0] k);
    return (k == KIND_MEM_WR) || (k == KIND_IO_WR);
  endfunction

  function automatic logic kindIo(input logic [2:0] k);
    return (k == KIND_IO_RD) || (k == KIND_IO_WR);
  endfunction

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic [2:0] kindIn,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       ale,
  output logic       rdN,
  output logic       wrN
);

  tState_e    state, stateNext;
  logic [2:0] kindQ;
  logic       accept;
  logic       dataPhase;

  assign accept = (state == ST_IDLE) && startIn && kindValid(kindIn);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept) stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = ST_T3;
      ST_T3:   stateNext = kindFetch(kindQ) ? ST_T4 : ST_IDLE;
      ST_T4:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kindQ <= KIND_FETCH;
    end else begin
      state <= stateNext;
      if (accept) kindQ <= kindIn;
    end
  end

  assign dataPhase = (state == ST_T2) || (state == ST_T3);

  always_comb begin
    strb.loadReq   = accept;
    strb.active    = (state != ST_IDLE);
    strb.driveAddr = (state == ST_T1);
    strb.driveData = dataPhase && kindWrites(kindQ);
    strb.capture   = (state == ST_T3) && kindReads(kindQ);
    strb.finish    = (state == ST_T3);
  end

  assign busy = (state != ST_IDLE);
  assign ale  = (state == ST_T1);
  assign rdN  = !(dataPhase && kindReads(kindQ));
  assign wrN  = !(dataPhase && kindWrites(kindQ));

  // R7: read and write strobes never overlap
  assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R7: each strobe stays low for exactly two periods
  assert_rd_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |=> !rdN ##1 rdN);
  assert_wr_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |=> !wrN ##1 wrN);

  // R4: address strobe lasts one period
  assert_ale_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R3: every cycle opens with the address strobe
  assert_cycle_opens_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ale);

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [2:0]        kindIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrDataIn,
  input  logic [DATA_W-1:0] adIn,
  output logic [HI_W-1:0]   addrHi,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              ioM,
  output logic              s1,
  output logic              s0,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  logic [2:0]        kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [HI_W-1:0]   hiSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ   <= KIND_FETCH;
      addrQ   <= '0;
      wrDataQ <= '0;
      rdData  <= '0;
      done    <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        kindQ   <= kindIn;
        addrQ   <= addrIn;
        wrDataQ <= wrDataIn;
      end
      if (strb.capture) rdData <= adIn;
      done <= strb.finish;
    end
  end

  // I/O cycles repeat the port number on the upper lines
  assign hiSel = kindIo(kindQ) ? HI_W'(addrQ[DATA_W-1:0]) : addrQ[ADDR_W-1:DATA_W];

  always_comb begin
    addrHi = strb.active ? hiSel : '0;
    adOut  = '0;
    if (strb.driveAddr)      adOut = addrQ[DATA_W-1:0];
    else if (strb.driveData) adOut = wrDataQ;
    adOe   = strb.driveAddr || strb.driveData;
    ioM    = strb.active && kindIo(kindQ);
    s1     = strb.active && kindReads(kindQ);
    s0     = strb.active && (kindFetch(kindQ) || kindWrites(kindQ));
  end

  // R9: completion is a single-period pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a capture is always followed by completion
  assert_capture_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> done);

  // R8: after T1 only writes drive the shared lines
  assert_oe_write_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (adOe && !strb.driveAddr) |-> kindWrites(kindQ));

  // R1: quiet bus while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> (!ioM && !s1 && !s0 && !adOe && addrHi == '0));

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startIn,
  input  logic [2:0]                 kindIn,
  input  logic [ADDR_W-1:0]          addrIn,
  input  logic [DATA_W-1:0]          wrDataIn,
  input  logic [DATA_W-1:0]          adIn,
  output logic                       busyOut,
  output logic                       doneOut,
  output logic [DATA_W-1:0]          rdDataOut,
  output logic [ADDR_W-DATA_W-1:0]   addrHiOut,
  output logic [DATA_W-1:0]          adOut,
  output logic                       adOeOut,
  output logic                       aleOut,
  output logic                       ioMOut,
  output logic                       s1Out,
  output logic                       s0Out,
  output logic                       rdNOut,
  output logic                       wrNOut
);

  seqStrobe_t strb;

  busSeqCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .kindIn  (kindIn),
    .strb    (strb),
    .busy    (busyOut),
    .ale     (aleOut),
    .rdN     (rdNOut),
    .wrN     (wrNOut)
  );

  busSeqDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .kindIn   (kindIn),
    .addrIn   (addrIn),
    .wrDataIn (wrDataIn),
    .adIn     (adIn),
    .addrHi   (addrHiOut),
    .adOut    (adOut),
    .adOe     (adOeOut),
    .ioM      (ioMOut),
    .s1       (s1Out),
    .s0       (s0Out),
    .rdData   (rdDataOut),
    .done     (doneOut)
  );

endmodule

// File: tb/test_busCycleSeq.sv
module test_busCycleSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [2:0]  kindIn = 3'd0;
  logic [15:0] addrIn = 16'h0;
  logic [7:0]  wrDataIn = 8'h0;
  logic [7:0]  adIn;
  logic        busyOut, doneOut, adOeOut, aleOut, ioMOut, s1Out, s0Out, rdNOut, wrNOut;
  logic [7:0]  rdDataOut, addrHiOut, adOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] lastRead = 8'h00;
  logic [7:0] latchLo = 8'h00;

  always #4 clk = ~clk;

  busCycleSeq i_busCycleSeq (
    .clk(clk), .rstN(rstN), .startIn(startIn), .kindIn(kindIn), .addrIn(addrIn),
    .wrDataIn(wrDataIn), .adIn(adIn), .busyOut(busyOut), .doneOut(doneOut),
    .rdDataOut(rdDataOut), .addrHiOut(addrHiOut), .adOut(adOut), .adOeOut(adOeOut),
    .aleOut(aleOut), .ioMOut(ioMOut), .s1Out(s1Out), .s0Out(s0Out),
    .rdNOut(rdNOut), .wrNOut(wrNOut)
  );

  function automatic logic [7:0] memFn(input logic [15:0] a);
    if (a == 16'h2000) return 8'h3E;
    if (a == 16'h2001) return 8'hFF;
    return (a[7:0] * 8'd3 + a[15:8]) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] ioFn(input logic [7:0] p);
    return ~p + 8'h11;
  endfunction

  // Bus-side model: demultiplex the low byte with the address strobe
  always @(negedge clk) if (aleOut) latchLo <= adOut;
  assign adIn = ioMOut ? ioFn(latchLo) : memFn({addrHiOut, latchLo});

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk({tag, " R1 busy"}, busyOut, 0);
    chk({tag, " R1 ale"}, aleOut, 0);
    chk({tag, " R1 rdN"}, rdNOut, 1);
    chk({tag, " R1 wrN"}, wrNOut, 1);
    chk({tag, " R1 oe"}, adOeOut, 0);
    chk({tag, " R1 status"}, {ioMOut, s1Out, s0Out}, 0);
    chk({tag, " R1 addrHi"}, addrHiOut, 0);
  endtask

  // poke: keep requesting a different cycle while busy
  task automatic runCycle(input logic [2:0] k, input logic [15:0] a,
                          input logic [7:0] w, input bit poke);
    int nT;
    bit rd, wr, io;
    logic [7:0] hi, lo, expRd;
    nT = (k == 3'd0) ? 4 : 3;
    rd = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    wr = (k == 3'd2) || (k == 3'd4);
    io = (k == 3'd3) || (k == 3'd4);
    lo = a[7:0];
    hi = io ? a[7:0] : a[15:8];
    expRd = io ? ioFn(lo) : memFn(a);
    @(negedge clk);
    startIn = 1'b1; kindIn = k; addrIn = a; wrDataIn = w;
    @(negedge clk);
    startIn = poke;
    if (poke) begin
      kindIn = (k == 3'd4) ? 3'd1 : 3'd4;
      addrIn = ~a; wrDataIn = ~w;
    end
    for (int t = 1; t <= nT; t++) begin
      if (t > 1) @(negedge clk);
      chk("R3 busy", busyOut, 1);
      chk("R4 ale", aleOut, (t == 1));
      chk("R5 addrHi", addrHiOut, hi);
      chk("R6 ioM", ioMOut, io);
      chk("R6 s1s0", {s1Out, s0Out}, (k == 3'd0) ? 2'b11 : (rd ? 2'b10 : 2'b01));
      if (t == 1) begin
        chk("R4 oe", adOeOut, 1);
        chk("R4/R5 lowByte", adOut, lo);
        chk("R7 idle strobes T1", {rdNOut, wrNOut}, 2'b11);
      end else if (t <= 3) begin
        chk("R7 rdN", rdNOut, !rd);
        chk("R7 wrN", wrNOut, !wr);
        chk("R8 oe", adOeOut, wr);
        if (wr) chk("R8 wrData", adOut, w);
      end else begin
        chk("R7 T4 strobes", {rdNOut, wrNOut}, 2'b11);
        chk("R8 T4 oe", adOeOut, 0);
        chk("R9 done T4", doneOut, 1);
        chk("R9 rdData fetch", rdDataOut, expRd);
      end
      if (t == nT) startIn = 1'b0;
    end
    if (rd) lastRead = expRd;
    @(negedge clk);
    if (nT == 3) begin
      chk("R9 done", doneOut, 1);
      chk("R9 rdData", rdDataOut, lastRead);
      chk("R3 length", busyOut, 0);
    end else begin
      chk("R9 done single", doneOut, 0);
      chk("R3 fetch length", busyOut, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chkIdle("reset");
    chk("R1 done", doneOut, 0);

    // Two-byte instruction: fetch then operand read
    runCycle(3'd0, 16'h2000, 8'h00, 1'b0);
    chk("R9 opcode held", rdDataOut, 8'h3E);
    runCycle(3'd1, 16'h2001, 8'h00, 1'b0);
    chk("R9 operand held", rdDataOut, 8'hFF);
    @(negedge clk);
    chkIdle("between");
    chk("R9 done cleared", doneOut, 0);

    // Sweep every kind over a set of addresses
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 16; i++) begin
        runCycle(3'(k), 16'(i * 16'h1357 + k * 16'h0101), 8'(i * 29 + k), 1'b0);
        if (k == 2 || k == 4) chk("R9 rdData held across write", rdDataOut, lastRead);
      end
    end

    // Illegal kind codes are ignored
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      startIn = 1'b1; kindIn = 3'(k); addrIn = 16'hBEEF;
      @(negedge clk);
      startIn = 1'b0;
      chk("R2 illegal kind busy", busyOut, 0);
      chk("R2 illegal kind ale", aleOut, 0);
      @(negedge clk);
      chk("R2 illegal kind no done", doneOut, 0);
    end

    // Requests while busy are ignored
    for (int k = 0; k < 5; k++) begin
      runCycle(3'(k), 16'(16'h4A20 + k * 16'h0F03), 8'(8'h5C + k), 1'b1);
      @(negedge clk);
      chk("R2 no queued cycle", busyOut, 0);
      chk("R2 no queued ale", aleOut, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule